// File: doc/BRIEF.md
# Compare-Match Output Unit

This block watches a free-running counter and gives a group of output pins a level that depends on timing. Each channel holds a compare value. On the first cycle in which the counter equals that value, a match event fires. The event sets the channel's sticky flag and applies the channel's programmed pin action: release, toggle, drive low or drive high. The master channel has no action code of its own. On its match it drives every pin selected by a mask input to the level given by a data input, and it is the only channel that drives its own pin. A force strobe applies a channel's action at once, without a match and without setting the flag.

Each pin is modelled as a two-state machine with the states LVL_LOW and LVL_HIGH. The transitions are SET (go to LVL_HIGH), CLEAR (go to LVL_LOW) and TOGGLE (go to the other state). A HOLD leaves the state as it is. The master channel's SET or CLEAR on a pin takes precedence over any action the pin's own channel takes in the same cycle. A pin that no compare function owns shows the general-purpose value given for it.

Top module: `oc_unit`

## Requirements
- R1: After reset every pin state is LVL_LOW, every flag is 0 and the interrupt output is 0.
- R2: A channel whose 2-bit action code is 00 does not own its pin: the pin shows the general-purpose input bit, and the channel's match changes neither the pin nor the pin state. Its flag still sets.
- R3: Action code 01 applies a TOGGLE on each match event of the channel.
- R4: Action code 10 applies a CLEAR on a match event. Action code 11 applies a SET.
- R5: A match event fires only in the first cycle of counter == compare. A counter that holds the equal value for more cycles produces no further event.
- R6: On a master match event, every pin whose mask bit is 1 goes to the value of its data bit. Pins whose mask bit is 0 keep their state. A pin whose mask bit is 1 is owned.
- R7: When the master channel and a pin's own channel act on that pin in the same cycle, the master's value wins.
- R8: A 1 on a force strobe bit applies that channel's action (the mask/data action for the master) in that cycle. It does not set the channel's flag.
- R9: A flag is set by a match event and stays set until a 1 on its clear bit. When a set and a clear occur in the same cycle, the set wins.
- R10: The interrupt output is 1 exactly when some flag is 1 and its enable bit is 1.
- R11: Channel k (k = 1 for the master, 2..NUM_CH for the rest) uses bit NUM_CH-k of the flag, force, clear, enable, mask, data, pin and ownership vectors. The master therefore uses the MSB, and channel 2 uses the next bit down. Action code field [2i+1:2i] belongs to pin i, for i < NUM_CH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CW | Free-running counter value |
| cmp_i | input | NUM_CH*CW | Compare values, slice i for bit i |
| act_i | input | 2*(NUM_CH-1) | Action codes of the non-master channels |
| mst_mask_i | input | NUM_CH | Pins that the master channel drives |
| mst_data_i | input | NUM_CH | Levels that the master channel drives |
| force_i | input | NUM_CH | One-cycle force strobes |
| flag_clr_i | input | NUM_CH | Write-1 flag clear strobes |
| irq_en_i | input | NUM_CH | Interrupt enables |
| gpio_i | input | NUM_CH | General-purpose levels for released pins |
| pin_o | output | NUM_CH | Pin levels |
| pin_own_o | output | NUM_CH | 1 where a compare function owns the pin |
| flag_o | output | NUM_CH | Sticky match flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench holds the counter on a compare value for several cycles. A design that triggers on the level rather than the first cycle would toggle again, or set the flag again after a clear. In one cycle it makes the master and a toggling channel hit the same pin; a wrong priority leaves the toggled level on the pin. It forces channels, including one whose bit lies next to the master's, and checks that no flag rises and that only the intended pin moves. It also clears a flag in the cycle of a new match, where a design that lets the clear win would lose the event.

// File: rtl/oc_pkg.sv
package oc_pkg;
    typedef enum logic [1:0] {
        ACT_OFF  = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } oc_act_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } oc_lvl_e;
endpackage

// File: rtl/oc_match.sv
module oc_match #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] cmp_i,
    output logic          event_o
);
    logic eq_w;
    logic eq_q;

    assign eq_w    = (count_i == cmp_i);
    assign event_o = eq_w & ~eq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_w;
    end

    // R5: a held equality yields no second event
    p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !(event_o && $stable(count_i) && $stable(cmp_i)));
endmodule

// File: rtl/oc_pin_fsm.sv
module oc_pin_fsm
    import oc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fire_i,
    input  oc_act_e code_i,
    input  logic    mst_fire_i,
    input  logic    mst_sel_i,
    input  logic    mst_val_i,
    output logic    level_o
);
    oc_lvl_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mst_fire_i && mst_sel_i) begin
            state_d = mst_val_i ? LVL_HIGH : LVL_LOW;
        end else if (fire_i) begin
            unique case (code_i)
                ACT_OFF:  state_d = state_q;
                ACT_LOW:  state_d = LVL_LOW;
                ACT_HIGH: state_d = LVL_HIGH;
                ACT_TOG: begin
                    unique case (state_q)
                        LVL_LOW:  state_d = LVL_HIGH;
                        LVL_HIGH: state_d = LVL_LOW;
                    endcase
                end
            endcase
        end
    end

    assign level_o = (state_q == LVL_HIGH);

    // R7: master selection overrides the channel action
    p_master_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_fire_i && mst_sel_i) |=> (level_o == $past(mst_val_i)));
    // R2: code 00 leaves the state alone
    p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && code_i == ACT_OFF && !(mst_fire_i && mst_sel_i)) |=> $stable(level_o));
    // R3: toggle inverts the level
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && code_i == ACT_TOG && !(mst_fire_i && mst_sel_i)) |=> (level_o != $past(level_o)));
endmodule

// File: rtl/oc_flags.sv
module oc_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    logic [N-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_i) | ev_i;
    end

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & en_i);

    // R9: an event always leaves its flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((flag_o & $past(ev_i)) == $past(ev_i)));
    // R9: a clear without an event drops the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~ev_i)) |=> ((flag_o & $past(clr_i & ~ev_i)) == '0));
endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CW     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          count_i,
    input  logic [NUM_CH*CW-1:0]   cmp_i,
    input  logic [2*(NUM_CH-1)-1:0] act_i,
    input  logic [NUM_CH-1:0]      mst_mask_i,
    input  logic [NUM_CH-1:0]      mst_data_i,
    input  logic [NUM_CH-1:0]      force_i,
    input  logic [NUM_CH-1:0]      flag_clr_i,
    input  logic [NUM_CH-1:0]      irq_en_i,
    input  logic [NUM_CH-1:0]      gpio_i,
    output logic [NUM_CH-1:0]      pin_o,
    output logic [NUM_CH-1:0]      pin_own_o,
    output logic [NUM_CH-1:0]      flag_o,
    output logic                   irq_o
);
    localparam int MST = NUM_CH - 1;

    logic [NUM_CH-1:0] ev_w;
    logic [NUM_CH-1:0] fire_w;
    logic [NUM_CH-1:0] lvl_w;
    logic [NUM_CH-1:0] code_own_w;

    assign fire_w = ev_w | force_i;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        oc_match #(.CW(CW)) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .count_i (count_i),
            .cmp_i   (cmp_i[i*CW +: CW]),
            .event_o (ev_w[i])
        );

        oc_act_e code_w;
        if (i == MST) begin : g_mst
            assign code_w = ACT_OFF;
        end else begin : g_reg
            assign code_w = oc_act_e'(act_i[2*i +: 2]);
        end
        assign code_own_w[i] = (code_w != ACT_OFF);

        oc_pin_fsm u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire_i     (fire_w[i]),
            .code_i     (code_w),
            .mst_fire_i (fire_w[MST]),
            .mst_sel_i  (mst_mask_i[i]),
            .mst_val_i  (mst_data_i[i]),
            .level_o    (lvl_w[i])
        );
    end

    assign pin_own_o = code_own_w | mst_mask_i;
    assign pin_o     = (pin_own_o & lvl_w) | (~pin_own_o & gpio_i);

    oc_flags #(.N(NUM_CH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev_w),
        .clr_i  (flag_clr_i),
        .en_i   (irq_en_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );

    // R8: a force without a match does not raise a flag
    p_force_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(force_i & ~ev_w & ~flag_o)) |=> ((flag_o & $past(force_i & ~ev_w & ~flag_o)) == '0));
    // R6: an unmasked pin keeps its state across a master-only event
    p_unmasked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_w[MST] && !mst_mask_i[0] && !fire_w[0]) |=> $stable(lvl_w[0]));
endmodule

// File: tb/oc_unit_tb.sv
module oc_unit_tb_top;
    localparam int N  = 5;
    localparam int CW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n;
    logic [CW-1:0]       count_i;
    logic [N*CW-1:0]     cmp_i;
    logic [2*(N-1)-1:0]  act_i;
    logic [N-1:0]        mst_mask_i, mst_data_i, force_i, flag_clr_i, irq_en_i, gpio_i;
    logic [N-1:0]        pin_o, pin_own_o, flag_o;
    logic                irq_o;

    oc_unit #(.NUM_CH(N), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .cmp_i(cmp_i), .act_i(act_i),
        .mst_mask_i(mst_mask_i), .mst_data_i(mst_data_i), .force_i(force_i),
        .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i), .gpio_i(gpio_i),
        .pin_o(pin_o), .pin_own_o(pin_own_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    typedef struct {
        string          tag;
        logic [N-1:0]   pin;
        logic [N-1:0]   own;
        logic [N-1:0]   flag;
        logic           irq;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_lvl, m_flag, m_prev;

    function automatic logic [1:0] code_of(int i);
        return (i == N-1) ? 2'b00 : act_i[2*i +: 2];
    endfunction

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic [CW-1:0] cnt, input logic [N-1:0] frc,
                        input logic [N-1:0] clr, input string tag);
        exp_t e;
        logic [N-1:0] ev, act;
        count_i    = cnt;
        force_i    = frc;
        flag_clr_i = clr;
        for (int i = 0; i < N; i++) begin
            logic m;
            m = (cnt == cmp_i[i*CW +: CW]);
            ev[i] = m && !m_prev[i];
            m_prev[i] = m;
        end
        act = ev | frc;
        for (int i = 0; i < N-1; i++) begin
            if (act[i]) begin
                case (code_of(i))
                    2'b01: m_lvl[i] = ~m_lvl[i];
                    2'b10: m_lvl[i] = 1'b0;
                    2'b11: m_lvl[i] = 1'b1;
                    default: ;
                endcase
            end
        end
        if (act[N-1]) m_lvl = (m_lvl & ~mst_mask_i) | (mst_data_i & mst_mask_i);
        m_flag = (m_flag & ~clr) | ev;
        e.tag = tag;
        for (int i = 0; i < N; i++) e.own[i] = mst_mask_i[i] || (code_of(i) != 2'b00);
        e.pin  = (e.own & m_lvl) | (~e.own & gpio_i);
        e.flag = m_flag;
        e.irq  = |(m_flag & irq_en_i);
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares each result shortly after the edge that produces it
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (pin_o !== e.pin || pin_own_o !== e.own || flag_o !== e.flag || irq_o !== e.irq) begin
                bad++;
                $display("FAIL %s: pin=%b own=%b flag=%b irq=%b expected pin=%b own=%b flag=%b irq=%b",
                         e.tag, pin_o, pin_own_o, flag_o, irq_o, e.pin, e.own, e.flag, e.irq);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        count_i = '0; force_i = '0; flag_clr_i = '0; irq_en_i = '0;
        mst_mask_i = '0; mst_data_i = '0; gpio_i = 5'b10101;
        // bit3 = ch2 toggle, bit2 = ch3 low, bit1 = ch4 high, bit0 = ch5 off
        act_i = {2'b01, 2'b10, 2'b11, 2'b00};
        cmp_i = {16'd500, 16'd100, 16'd200, 16'd300, 16'd400};
        m_lvl = '0; m_flag = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(16'd0,   '0, '0, "R1 reset state");
        step(16'd100, '0, '0, "R3 toggle to high");
        step(16'd100, '0, '0, "R5 held equality no second event");
        step(16'd100, '0, '0, "R5 held equality again");
        step(16'd101, '0, '0, "R3 idle");
        step(16'd100, '0, '0, "R3 toggle back low");
        step(16'd200, '0, '0, "R4 clear action");
        step(16'd300, '0, '0, "R4 set action");
        step(16'd400, '0, '0, "R2 code 00 flag only");
        gpio_i = 5'b01010;
        step(16'd401, '0, '0, "R2 released pin follows gpio");
        step(16'd100, '0, 5'b11111, "R9 set wins over clear");
        step(16'd101, '0, 5'b00100, "R9 clear drops flag");
        irq_en_i = 5'b01000;
        step(16'd102, '0, '0, "R10 irq from enabled flag");
        irq_en_i = 5'b00010;
        step(16'd103, '0, '0, "R10 irq off when flag masked");
        step(16'd104, '0, 5'b11111, "R9 clear all");
        act_i[5:4] = 2'b11;
        step(16'd105, 5'b00100, '0, "R8 force set without flag");
        step(16'd106, 5'b01000, '0, "R11 force bit3 moves only channel 2 pin");
        mst_mask_i = 5'b11000; mst_data_i = 5'b10000;
        cmp_i[3*CW +: CW] = 16'd500;
        step(16'd500, '0, '0, "R7 master overrides toggle, R6 masked pins");
        mst_mask_i = 5'b10011; mst_data_i = 5'b00001;
        step(16'd501, 5'b10000, '0, "R8 master force, R6 unmasked hold");
        step(16'd502, '0, '0, "R6 steady after master force");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule